// File: doc/BRIEF.md
# Serial Status Flag Controller

This block keeps the status bits that sit beside the data registers of a serial port that can also run in smart-card mode: a "transmit buffer empty" flag, a "receive buffer full" flag and a sticky overrun flag. The flags change on events reported by the serial engine and by the data-register path. The engine reports that the transmit byte moved into the shifter, or that a byte arrived without error. The data-register path reports that a DMA or transfer engine touched a data register because an interrupt request was active.

Software clears a flag with a handshake. It first reads the status byte while the flag shows 1, and then writes the byte back with that flag's bit at 0. Each flag keeps its own armed state between the read and the write. The two interrupt requests come straight from the flags and their enables. The status byte is assembled combinationally from the current flags, so a read returns the values held at that moment.

Top module: `ser_stat_flags`

## Requirements
- R1: While reset is asserted and right after it, tx_empty is 1, rx_full is 0 and overrun is 0, and no flag is armed.
- R2: In any cycle where tx_en is 0, tx_empty is 1 after the next clock edge, whatever else happens in that cycle.
- R3: A tx_load pulse (holding byte moved to the shifter) makes tx_empty 1 after the next edge.
- R4: An rx_done pulse with rx_en at 1 makes rx_full 1 after the next edge. An rx_done pulse with rx_en at 0 is ignored. Dropping rx_en leaves rx_full and overrun unchanged.
- R5: The status byte puts tx_empty at bit 7, rx_full at bit 6 and overrun at bit 5, with all other bits 0. A stat_rd while a flag reads 1 arms that flag. A later stat_wr with that flag's bit at 0 clears the flag at the next edge.
- R6: A stat_wr clears nothing in these cases: the flag's bit is written as 1, the flag is not armed, or the flag was 0 when last read. Every stat_wr disarms all flags. Arming is tracked per flag, so one write can clear one flag and keep another.
- R7: dma_txd_wr clears tx_empty only in a cycle where tx_irq is 1. Otherwise it has no effect.
- R8: dma_rxd_rd clears rx_full only in a cycle where rx_irq is 1. Otherwise it has no effect.
- R9: A received byte accepted while rx_full is already 1 sets overrun at the next edge, and rx_full stays 1. Overrun stays set until the read-then-write-0 handshake clears it.
- R10: tx_irq equals tx_empty AND txi_en, and rx_irq equals rx_full AND rxi_en, combinationally.
- R11: When a set event and a clear event reach the same flag in the same cycle, the flag ends up 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| tx_en | input | 1 | Transmitter enable |
| rx_en | input | 1 | Receiver enable |
| tx_load | input | 1 | Pulse: holding byte moved into the transmit shifter |
| rx_done | input | 1 | Pulse: reception finished without error |
| txi_en | input | 1 | Transmit interrupt enable |
| rxi_en | input | 1 | Receive interrupt enable |
| stat_rd | input | 1 | CPU read strobe of the status byte |
| stat_wr | input | 1 | CPU write strobe of the status byte |
| stat_wdata | input | DATA_W | CPU write data |
| stat_rdata | output | DATA_W | Status byte as seen by a read |
| dma_txd_wr | input | 1 | DMA or transfer-engine write of the transmit data register |
| dma_rxd_rd | input | 1 | DMA or transfer-engine read of the receive data register |
| tx_empty | output | 1 | Transmit buffer empty flag |
| rx_full | output | 1 | Receive buffer full flag |
| overrun | output | 1 | Sticky overrun flag |
| tx_irq | output | 1 | Transmit interrupt request |
| rx_irq | output | 1 | Receive interrupt request |

## Verification
The bench builds the block with its default parameters: an 8-bit status byte with the flags at bits 7, 6 and 5. A directed pass walks through each clear path and each conflict by hand. A sweep then applies all 8192 combinations of the thirteen event, strobe, enable and write-bit inputs, in a scrambled order, against an arithmetic model of the three flags and their armed states. The walk is long enough to reach every pairing: armed and unarmed writes, DMA accesses with the request on and off, and set events colliding with clears.

// File: rtl/ssf_pkg.sv
package ssf_pkg;

  localparam int NFLAG = 3;

  typedef enum logic [1:0] {
    FLG_TXE = 2'd0,
    FLG_RXF = 2'd1,
    FLG_OVR = 2'd2
  } flag_id_e;

  // value a flag takes under reset: only the transmit-empty flag starts at 1
  function automatic logic flag_reset_value(input int idx);
    return (idx == int'(FLG_TXE));
  endfunction

  // set dominates clear
  function automatic logic next_flag(input logic cur, input logic set_ev,
                                     input logic clr_ev);
    logic n;
    n = cur;
    if (clr_ev) n = 1'b0;
    if (set_ev) n = 1'b1;
    return n;
  endfunction

  // a read captures the flag as seen; any write consumes the arming
  function automatic logic next_arm(input logic cur, input logic flag,
                                    input logic rd, input logic wr);
    logic n;
    n = cur;
    if (wr) n = 1'b0;
    if (rd) n = flag;
    return n;
  endfunction

  // software clear: armed, currently 1, written with a zero bit
  function automatic logic handshake_clear(input logic armed, input logic flag,
                                           input logic wr, input logic wbit);
    return armed & flag & wr & ~wbit;
  endfunction

endpackage

// File: rtl/ssf_flag_cell.sv
module ssf_flag_cell #(
  parameter logic RST_VAL = 1'b0
) (
  input  logic clk,
  input  logic rst_n,
  input  logic set_ev,
  input  logic ext_clr,
  input  logic rd_stb,
  input  logic wr_stb,
  input  logic wr_bit,
  output logic flag,
  output logic armed,
  output logic hs_clr
);
  logic flag_q;
  logic arm_q;

  assign hs_clr = ssf_pkg::handshake_clear(arm_q, flag_q, wr_stb, wr_bit);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      flag_q <= RST_VAL;
      arm_q  <= 1'b0;
    end else begin
      flag_q <= ssf_pkg::next_flag(flag_q, set_ev, hs_clr | ext_clr);
      arm_q  <= ssf_pkg::next_arm(arm_q, flag_q, rd_stb, wr_stb);
    end
  end

  assign flag  = flag_q;
  assign armed = arm_q;
endmodule

// File: rtl/ssf_event_gen.sv
module ssf_event_gen
  import ssf_pkg::*;
(
  input  logic             tx_en,
  input  logic             rx_en,
  input  logic             tx_load,
  input  logic             rx_done,
  input  logic             dma_txd_wr,
  input  logic             dma_rxd_rd,
  input  logic             tx_irq,
  input  logic             rx_irq,
  input  logic             rx_full,
  output logic             rx_accept,
  output logic [NFLAG-1:0] set_vec,
  output logic [NFLAG-1:0] ext_clr_vec
);
  assign rx_accept = rx_done & rx_en;

  always_comb begin
    set_vec     = '0;
    ext_clr_vec = '0;
    set_vec[FLG_TXE]     = ~tx_en | tx_load;
    set_vec[FLG_RXF]     = rx_accept;
    set_vec[FLG_OVR]     = rx_accept & rx_full;
    ext_clr_vec[FLG_TXE] = dma_txd_wr & tx_irq;
    ext_clr_vec[FLG_RXF] = dma_rxd_rd & rx_irq;
  end
endmodule

// File: rtl/ssf_status_pack.sv
module ssf_status_pack
  import ssf_pkg::*;
#(
  parameter int DATA_W  = 8,
  parameter int TXE_POS = 7,
  parameter int RXF_POS = 6,
  parameter int OVR_POS = 5
) (
  input  logic [NFLAG-1:0]  flags,
  input  logic [DATA_W-1:0] wdata,
  output logic [DATA_W-1:0] rdata,
  output logic [NFLAG-1:0]  wbits
);
  localparam int POS [NFLAG] = '{TXE_POS, RXF_POS, OVR_POS};

  always_comb begin
    rdata = '0;
    wbits = '0;
    for (int i = 0; i < NFLAG; i++) begin
      rdata[POS[i]] = flags[i];
      wbits[i]      = wdata[POS[i]];
    end
  end
endmodule

// File: rtl/ser_stat_flags.sv
module ser_stat_flags
  import ssf_pkg::*;
#(
  parameter int DATA_W  = 8,
  parameter int TXE_POS = 7,
  parameter int RXF_POS = 6,
  parameter int OVR_POS = 5
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              tx_en,
  input  logic              rx_en,
  input  logic              tx_load,
  input  logic              rx_done,
  input  logic              txi_en,
  input  logic              rxi_en,
  input  logic              stat_rd,
  input  logic              stat_wr,
  input  logic [DATA_W-1:0] stat_wdata,
  output logic [DATA_W-1:0] stat_rdata,
  input  logic              dma_txd_wr,
  input  logic              dma_rxd_rd,
  output logic              tx_empty,
  output logic              rx_full,
  output logic              overrun,
  output logic              tx_irq,
  output logic              rx_irq
);
  // named internal events, visible to the bound checker
  logic [NFLAG-1:0] flag_vec;
  logic [NFLAG-1:0] arm_vec;
  logic [NFLAG-1:0] hs_clr_vec;
  logic [NFLAG-1:0] set_vec;
  logic [NFLAG-1:0] ext_clr_vec;
  logic [NFLAG-1:0] wbit_vec;
  logic             rx_accept;

  assign tx_empty = flag_vec[FLG_TXE];
  assign rx_full  = flag_vec[FLG_RXF];
  assign overrun  = flag_vec[FLG_OVR];
  assign tx_irq   = tx_empty & txi_en;
  assign rx_irq   = rx_full & rxi_en;

  ssf_event_gen u_events (
    .tx_en       (tx_en),
    .rx_en       (rx_en),
    .tx_load     (tx_load),
    .rx_done     (rx_done),
    .dma_txd_wr  (dma_txd_wr),
    .dma_rxd_rd  (dma_rxd_rd),
    .tx_irq      (tx_irq),
    .rx_irq      (rx_irq),
    .rx_full     (rx_full),
    .rx_accept   (rx_accept),
    .set_vec     (set_vec),
    .ext_clr_vec (ext_clr_vec)
  );

  ssf_status_pack #(
    .DATA_W  (DATA_W),
    .TXE_POS (TXE_POS),
    .RXF_POS (RXF_POS),
    .OVR_POS (OVR_POS)
  ) u_pack (
    .flags (flag_vec),
    .wdata (stat_wdata),
    .rdata (stat_rdata),
    .wbits (wbit_vec)
  );

  for (genvar g = 0; g < NFLAG; g++) begin : g_flag
    ssf_flag_cell #(
      .RST_VAL (flag_reset_value(g))
    ) u_cell (
      .clk     (clk),
      .rst_n   (rst_n),
      .set_ev  (set_vec[g]),
      .ext_clr (ext_clr_vec[g]),
      .rd_stb  (stat_rd),
      .wr_stb  (stat_wr),
      .wr_bit  (wbit_vec[g]),
      .flag    (flag_vec[g]),
      .armed   (arm_vec[g]),
      .hs_clr  (hs_clr_vec[g])
    );
  end
endmodule

// File: rtl/ssf_checker.sv
module ssf_checker #(
  parameter int DATA_W  = 8,
  parameter int RXF_POS = 6
) (
  input logic              clk,
  input logic              rst_n,
  input logic              tx_en,
  input logic              rx_en,
  input logic              tx_load,
  input logic              rx_done,
  input logic              stat_wr,
  input logic [DATA_W-1:0] stat_wdata,
  input logic              dma_txd_wr,
  input logic              dma_rxd_rd,
  input logic              tx_empty,
  input logic              rx_full,
  input logic              overrun,
  input logic              tx_irq,
  input logic              rx_irq,
  input logic [2:0]        arm_vec
);
  AST_TXE_FORCED: assert property (@(posedge clk) disable iff (!rst_n)
    !tx_en |=> tx_empty); // R2
  AST_TXE_LOAD: assert property (@(posedge clk) disable iff (!rst_n)
    tx_load |=> tx_empty); // R3
  AST_RXF_SET: assert property (@(posedge clk) disable iff (!rst_n)
    (rx_done && rx_en) |=> rx_full); // R4
  AST_RXF_KEEP: assert property (@(posedge clk) disable iff (!rst_n)
    (rx_full && !stat_wr && !dma_rxd_rd) |=> rx_full); // R4
  AST_UNARMED_WR: assert property (@(posedge clk) disable iff (!rst_n)
    (stat_wr && !arm_vec[0] && tx_empty && !dma_txd_wr) |=> tx_empty); // R6
  AST_WR_ONE: assert property (@(posedge clk) disable iff (!rst_n)
    (stat_wr && stat_wdata[RXF_POS] && rx_full && !dma_rxd_rd) |=> rx_full); // R6
  AST_OVR_SET: assert property (@(posedge clk) disable iff (!rst_n)
    (rx_done && rx_en && rx_full) |=> (overrun && rx_full)); // R9
  AST_OVR_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
    (overrun && !stat_wr) |=> overrun); // R9
  AST_TXI_NEEDS_FLAG: assert property (@(posedge clk) disable iff (!rst_n)
    tx_irq |-> tx_empty); // R10
  AST_RXI_NEEDS_FLAG: assert property (@(posedge clk) disable iff (!rst_n)
    rx_irq |-> rx_full); // R10
endmodule

bind ser_stat_flags ssf_checker #(
  .DATA_W  (DATA_W),
  .RXF_POS (RXF_POS)
) u_ssf_checker (
  .clk        (clk),
  .rst_n      (rst_n),
  .tx_en      (tx_en),
  .rx_en      (rx_en),
  .tx_load    (tx_load),
  .rx_done    (rx_done),
  .stat_wr    (stat_wr),
  .stat_wdata (stat_wdata),
  .dma_txd_wr (dma_txd_wr),
  .dma_rxd_rd (dma_rxd_rd),
  .tx_empty   (tx_empty),
  .rx_full    (rx_full),
  .overrun    (overrun),
  .tx_irq     (tx_irq),
  .rx_irq     (rx_irq),
  .arm_vec    (arm_vec)
);

// File: tb/ser_stat_flags_test.sv
module ser_stat_flags_test;
  localparam int CLK_P = 10;

  logic       clk = 1'b0;
  logic       rst_n;
  logic       tx_en, rx_en, tx_load, rx_done, txi_en, rxi_en;
  logic       stat_rd, stat_wr, dma_txd_wr, dma_rxd_rd;
  logic [7:0] stat_wdata, stat_rdata;
  logic       tx_empty, rx_full, overrun, tx_irq, rx_irq;

  int n_chk  = 0;
  int n_fail = 0;

  always #(CLK_P/2) clk = ~clk;

  ser_stat_flags uut (
    .clk(clk), .rst_n(rst_n), .tx_en(tx_en), .rx_en(rx_en),
    .tx_load(tx_load), .rx_done(rx_done), .txi_en(txi_en), .rxi_en(rxi_en),
    .stat_rd(stat_rd), .stat_wr(stat_wr), .stat_wdata(stat_wdata),
    .stat_rdata(stat_rdata), .dma_txd_wr(dma_txd_wr), .dma_rxd_rd(dma_rxd_rd),
    .tx_empty(tx_empty), .rx_full(rx_full), .overrun(overrun),
    .tx_irq(tx_irq), .rx_irq(rx_irq)
  );

  task automatic check(input string req, input logic [7:0] act, input logic [7:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %02h expected %02h", req, act, exp);
    end
  endtask

  // status byte expected from three flag values: bit7 tx, bit6 rx, bit5 ovr
  function automatic logic [7:0] sbyte(input logic t, input logic r, input logic o);
    return 8'((t ? 128 : 0) + (r ? 64 : 0) + (o ? 32 : 0));
  endfunction

  task automatic cyc();
    @(posedge clk);
    #1;
  endtask

  task automatic quiet();
    tx_load = 0; rx_done = 0; stat_rd = 0; stat_wr = 0;
    dma_txd_wr = 0; dma_rxd_rd = 0; stat_wdata = 8'h00;
  endtask

  task automatic do_reset();
    quiet();
    rst_n = 0;
    repeat (3) cyc();
    rst_n = 1;
  endtask

  task automatic rd_wr(input logic [7:0] d);
    stat_rd = 1; cyc(); stat_rd = 0;
    stat_wr = 1; stat_wdata = d; cyc(); quiet();
  endtask

  initial begin
    #(CLK_P * 150000);
    n_chk++; n_fail++;
    $display("FAIL watchdog: actual running expected finished");
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    logic m_t, m_r, m_o, a_t, a_r, a_o;
    logic n_t, n_r, n_o, acc;
    tx_en = 1; rx_en = 1; txi_en = 0; rxi_en = 0;
    do_reset();
    check("R1 reset byte", stat_rdata, 8'h80);
    check("R1 reset irq", {6'd0, tx_irq, rx_irq}, 8'h00);

    // R7: DMA write clears only while the request is up
    txi_en = 1; #1;
    check("R10 tx_irq up", {7'd0, tx_irq}, 8'h01);
    dma_txd_wr = 1; cyc(); quiet();
    check("R7 dma clears tx", {7'd0, tx_empty}, 8'h00);
    check("R10 tx_irq down", {7'd0, tx_irq}, 8'h00);
    tx_load = 1; cyc(); quiet();
    check("R3 load sets tx", {7'd0, tx_empty}, 8'h01);
    txi_en = 0; dma_txd_wr = 1; cyc(); quiet();
    check("R7 dma without irq ignored", {7'd0, tx_empty}, 8'h01);

    // R6 unarmed write, R5 handshake
    stat_wr = 1; stat_wdata = 8'h00; cyc(); quiet();
    check("R6 unarmed write ignored", stat_rdata, 8'h80);
    rd_wr(8'h00);
    check("R5 handshake clears tx", stat_rdata, 8'h00);
    tx_en = 0; cyc(); tx_en = 1;
    check("R2 disabled tx forces empty", {7'd0, tx_empty}, 8'h01);

    // receive side
    rxi_en = 1; rx_done = 1; cyc(); quiet();
    check("R4 rx_done sets full", stat_rdata, 8'hC0);
    check("R10 rx_irq up", {7'd0, rx_irq}, 8'h01);
    rx_en = 0; cyc();
    check("R4 rx_en low keeps full", stat_rdata, 8'hC0);
    rx_done = 1; cyc(); quiet();
    check("R4 rx_done ignored while disabled", stat_rdata, 8'hC0);
    rx_en = 1; rx_done = 1; cyc(); quiet();
    check("R9 overrun on second byte", stat_rdata, 8'hE0);

    stat_rd = 1; cyc(); stat_rd = 0;
    stat_wr = 1; stat_wdata = 8'hE0; cyc();
    stat_wdata = 8'h00; cyc(); quiet();
    check("R6 write ones then disarmed zero", stat_rdata, 8'hE0);
    rd_wr(8'hBF);
    check("R6 per-flag clear of rx only", stat_rdata, 8'hA0);

    rx_done = 1; cyc(); quiet();
    rxi_en = 0; dma_rxd_rd = 1; cyc(); quiet();
    check("R8 dma read without irq ignored", stat_rdata, 8'hE0);
    rxi_en = 1; dma_rxd_rd = 1; cyc(); quiet();
    check("R8 dma read clears rx", stat_rdata, 8'hA0);
    rd_wr(8'hDF);
    check("R9 handshake clears overrun", stat_rdata, 8'h80);

    // R11: set beats clear on both flags
    rx_done = 1; cyc(); quiet();
    stat_rd = 1; cyc(); stat_rd = 0;
    stat_wr = 1; stat_wdata = 8'h00; rx_done = 1; tx_load = 1; cyc(); quiet();
    check("R11 set wins over clear", stat_rdata, 8'hE0);

    // sweep every input combination against an arithmetic model
    do_reset();
    m_t = 1; m_r = 0; m_o = 0; a_t = 0; a_r = 0; a_o = 0;
    for (int i = 0; i < 8192; i++) begin
      logic [12:0] v;
      v = 13'((i * 2653 + 77) % 8192);
      tx_en = v[0]; tx_load = v[1]; rx_done = v[2]; dma_txd_wr = v[3];
      dma_rxd_rd = v[4]; txi_en = v[5]; rxi_en = v[6]; stat_rd = v[7];
      stat_wr = v[8]; stat_wdata = {v[9], v[10], v[11], 5'b0}; rx_en = v[12];
      #1;
      check("R10 sweep irqs", {6'd0, tx_irq, rx_irq}, {6'd0, m_t & v[5], m_r & v[6]});
      check("R5 sweep byte", stat_rdata, sbyte(m_t, m_r, m_o));
      acc = v[2] & v[12];
      n_t = m_t; n_r = m_r; n_o = m_o;
      if ((v[8] && !v[9] && a_t && m_t) || (v[3] && m_t && v[5])) n_t = 0;
      if ((v[8] && !v[10] && a_r && m_r) || (v[4] && m_r && v[6])) n_r = 0;
      if (v[8] && !v[11] && a_o && m_o) n_o = 0;
      if (!v[0] || v[1]) n_t = 1;
      if (acc) n_r = 1;
      if (acc && m_r) n_o = 1;
      if (v[7]) begin a_t = m_t; a_r = m_r; a_o = m_o; end
      else if (v[8]) begin a_t = 0; a_r = 0; a_o = 0; end
      m_t = n_t; m_r = n_r; m_o = n_o;
      cyc();
      check("R2 R3 R4 R6 R7 R8 R9 R11 sweep flags", stat_rdata, sbyte(m_t, m_r, m_o));
    end

    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule